// File: doc/BRIEF.md
# ECC Read-Modify-Write Sequencer

This block sits between a memory command front end and the scheduling queue of a DRAM controller whose stored words carry an error-correcting code. Each incoming request is turned into the command sequence the queue must see. Reads, full-word writes and any write made while the code is switched off pass straight through as one command. When the code is on, a write that leaves some byte lanes untouched is split into a read of the word followed by a write of the whole word. The block merges the fresh bytes into the returned, already corrected read data and presents that word to the downstream encoder.

The block also scrubs memory. A user read that comes back with a correctable error, while write-back is enabled, marks its address for correction. The sequencer then runs a new read and write at that address. It uses a new read rather than the failing data, so that a write landing in between is not lost. If the block's own read comes back uncorrectable, the sequence is dropped and nothing is written.

A central state machine has four states. S_IDLE passes commands through. It moves to S_RD_ISSUE when a scrub is pending or a partial ECC write is accepted. S_RD_ISSUE holds the read until it is accepted, then moves to S_RD_WAIT. S_RD_WAIT waits for the block's own read data. It goes to S_WR_ISSUE with the merged word, or back to S_IDLE on an uncorrectable error. S_WR_ISSUE holds the merged write until it is accepted, then returns to S_IDLE. No new request is taken while the machine is outside S_IDLE, so later commands to the same address always follow the pending write.

Top module: `ecc_rmw_sequencer`

## Requirements
- R1: After reset no command is presented while no request is valid, and `req_ready` equals `cmd_ready`.
- R2: A read request passes through in the same cycle as one command with `cmd_write`=0, the same address, and `cmd_own`=0.
- R3: A write whose byte enables are all ones passes through as one write with mask all ones and unchanged data, with ECC on or off.
- R4: With `cfg_ecc_en`=0, a write with any byte enables passes through as one write with `cmd_mask` equal to `req_be` and no read.
- R5: With `cfg_ecc_en`=1, a write with at least one clear enable produces no command in its accept cycle. It produces a read with `cmd_own`=1 at its address in the next cycle. No further command appears until a return with `rd_own`=1 is seen.
- R6: The write of a pair has `cmd_own`=1, mask all ones and data in which byte lane i (bits 8i+7..8i) is taken from the request when `req_be[i]`=1 and from `rd_data` otherwise. It appears the cycle after the own read returns.
- R7: `req_ready` stays 0 from the cycle after a sequence starts until its write is accepted or it is abandoned.
- R8: A return with `rd_own`=0, `rd_sbe`=1 and `rd_dbe`=0, while both `cfg_ecc_en` and `cfg_scrub_en` are 1, leads to a fresh own read at `rd_addr`. The write that follows carries the new read data unchanged.
- R9: With `cfg_scrub_en`=0, a correctable error return starts no command.
- R10: An own read returning with `rd_dbe`=1 ends the sequence with no write, and the block is idle and ready on the next cycle.
- R11: A pending scrub is served before a waiting request. That request is held off with `req_ready`=0 and passes through after the scrub write.
- R12: While `cmd_ready` is 0, an own command stays valid with stable address, direction and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ecc_en | input | 1 | ECC protection enabled |
| cfg_scrub_en | input | 1 | Write-back of correctable errors enabled |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, bit i covers bits 8i+7..8i |
| cmd_valid | output | 1 | Command valid toward the scheduler |
| cmd_ready | input | 1 | Scheduler accepts command |
| cmd_write | output | 1 | 1 = write command |
| cmd_addr | output | ADDR_W | Command address |
| cmd_mask | output | DATA_W/8 | Byte mask of write command |
| cmd_wdata | output | DATA_W | Write word toward the encoder |
| cmd_own | output | 1 | Command generated by this block's sequence |
| rd_valid | input | 1 | Read return valid |
| rd_own | input | 1 | Return belongs to a read with cmd_own set |
| rd_addr | input | ADDR_W | Address of the returned read |
| rd_data | input | DATA_W | Corrected read data |
| rd_sbe | input | 1 | Correctable error was found |
| rd_dbe | input | 1 | Uncorrectable error was found |

## Verification
The bench builds the block with a 16-bit address and a 32-bit word, so four byte lanes. Every pattern of the four enables can then be reached, including all-clear and all-set. Random mixes of reads, full and partial writes, ECC on and off and random read-return delays exercise the pass-through and merge paths. Directed cases cover scrubbing, held requests, disabled write-back, abandoned sequences and back-pressure.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_RD_ISSUE = 2'd1,
        S_RD_WAIT  = 2'd2,
        S_WR_ISSUE = 2'd3
    } rmw_state_t;
endpackage

// File: rtl/rmw_req_classify.sv
module rmw_req_classify #(
    parameter int NB = 4
) (
    input  logic          ecc_en,
    input  logic          is_write,
    input  logic [NB-1:0] be,
    output logic          full_word,
    output logic          needs_rmw
);
    always_comb begin
        full_word = &be;
        needs_rmw = ecc_en && is_write && !full_word;
    end
endmodule

// File: rtl/rmw_byte_merge.sv
module rmw_byte_merge #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   old_word,
    input  logic [DATA_W-1:0]   new_word,
    input  logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0]   merged
);
    localparam int NB = DATA_W / 8;
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign merged[8*i +: 8] = be[i] ? new_word[8*i +: 8] : old_word[8*i +: 8];
    end
endmodule

// File: rtl/ecc_rmw_sequencer.sv
module ecc_rmw_sequencer
    import rmw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_ecc_en,
    input  logic                cfg_scrub_en,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic                cmd_valid,
    input  logic                cmd_ready,
    output logic                cmd_write,
    output logic [ADDR_W-1:0]   cmd_addr,
    output logic [DATA_W/8-1:0] cmd_mask,
    output logic [DATA_W-1:0]   cmd_wdata,
    output logic                cmd_own,
    input  logic                rd_valid,
    input  logic                rd_own,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [DATA_W-1:0]   rd_data,
    input  logic                rd_sbe,
    input  logic                rd_dbe
);
    localparam int NB = DATA_W / 8;

    rmw_state_t        state_q, state_d;
    logic [ADDR_W-1:0] hold_addr_q;
    logic [DATA_W-1:0] hold_data_q;
    logic [NB-1:0]     hold_be_q;
    logic [DATA_W-1:0] merged_q, merged_w;
    logic              scrub_pend_q;
    logic [ADDR_W-1:0] scrub_addr_q;
    logic              full_word, needs_rmw;
    logic              own_ret, start_scrub, start_pair, scrub_hit;

    rmw_req_classify #(.NB(NB)) u_cls (
        .ecc_en    (cfg_ecc_en),
        .is_write  (req_write),
        .be        (req_be),
        .full_word (full_word),
        .needs_rmw (needs_rmw)
    );

    rmw_byte_merge #(.DATA_W(DATA_W)) u_merge (
        .old_word (rd_data),
        .new_word (hold_data_q),
        .be       (hold_be_q),
        .merged   (merged_w)
    );

    always_comb begin
        own_ret     = rd_valid && rd_own;
        start_scrub = (state_q == S_IDLE) && scrub_pend_q;
        start_pair  = (state_q == S_IDLE) && !scrub_pend_q && req_valid && cmd_ready && needs_rmw;
        scrub_hit   = rd_valid && !rd_own && rd_sbe && !rd_dbe && cfg_ecc_en && cfg_scrub_en
                      && !scrub_pend_q;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start_scrub || start_pair) state_d = S_RD_ISSUE;
            S_RD_ISSUE: if (cmd_ready) state_d = S_RD_WAIT;
            S_RD_WAIT:  if (own_ret) state_d = rd_dbe ? S_IDLE : S_WR_ISSUE;
            S_WR_ISSUE: if (cmd_ready) state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // sequence data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_addr_q  <= '0;
            hold_data_q  <= '0;
            hold_be_q    <= '0;
            merged_q     <= '0;
            scrub_pend_q <= 1'b0;
            scrub_addr_q <= '0;
        end else begin
            if (start_scrub) begin
                hold_addr_q  <= scrub_addr_q;
                hold_be_q    <= '0;
                scrub_pend_q <= 1'b0;
            end else if (start_pair) begin
                hold_addr_q <= req_addr;
                hold_data_q <= req_wdata;
                hold_be_q   <= req_be;
            end
            if (scrub_hit) begin
                scrub_pend_q <= 1'b1;
                scrub_addr_q <= rd_addr;
            end
            if (state_q == S_RD_WAIT && own_ret) merged_q <= merged_w;
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        cmd_valid = 1'b0;
        cmd_write = 1'b0;
        cmd_addr  = hold_addr_q;
        cmd_mask  = '1;
        cmd_wdata = merged_q;
        cmd_own   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = cmd_ready && !scrub_pend_q;
                if (!scrub_pend_q && req_valid && !needs_rmw) begin
                    cmd_valid = 1'b1;
                    cmd_write = req_write;
                    cmd_addr  = req_addr;
                    cmd_mask  = req_write ? req_be : '1;
                    cmd_wdata = req_wdata;
                end
            end
            S_RD_ISSUE: begin
                cmd_valid = 1'b1;
                cmd_own   = 1'b1;
            end
            S_RD_WAIT: ;
            S_WR_ISSUE: begin
                cmd_valid = 1'b1;
                cmd_write = 1'b1;
                cmd_own   = 1'b1;
            end
            default: ;
        endcase
    end

    // R7
    busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |-> !req_ready);

    // R5
    pair_wr_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == S_WR_ISSUE) |-> $past(rd_valid && rd_own && !rd_dbe));

    // R6
    own_wr_full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_own && cmd_write) |-> (&cmd_mask));

    // R10
    dbe_abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD_WAIT && rd_valid && rd_own && rd_dbe) |=> (state_q == S_IDLE));

    // R12
    own_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_own && !cmd_ready) |=>
            (cmd_valid && cmd_own && $stable(cmd_addr) && $stable(cmd_write) && $stable(cmd_wdata)));
endmodule

// File: tb/sim_ecc_rmw_sequencer.sv
module sim_ecc_rmw_sequencer;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int NB = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_ecc_en = 1'b1, cfg_scrub_en = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [NB-1:0] req_be = '0;
    logic          cmd_valid, cmd_write, cmd_own;
    logic          cmd_ready = 1'b1;
    logic [AW-1:0] cmd_addr;
    logic [NB-1:0] cmd_mask;
    logic [DW-1:0] cmd_wdata;
    logic          rd_valid = 1'b0, rd_own = 1'b0, rd_sbe = 1'b0, rd_dbe = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data = '0;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    ecc_rmw_sequencer #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge_ref(logic [DW-1:0] oldw, logic [DW-1:0] neww, logic [NB-1:0] be);
        logic [DW-1:0] r;
        for (int i = 0; i < NB; i++) r[8*i +: 8] = be[i] ? neww[8*i +: 8] : oldw[8*i +: 8];
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_idle_cmd(input string req);
        #2;
        chk(cmd_valid == 1'b0, req, cmd_valid, 0);
    endtask

    // one request; returns after the machine is back in idle, at a negedge
    task automatic do_req(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [NB-1:0] be, input logic [DW-1:0] rdat, input int wait_cyc,
                          input logic dbe);
        logic rmw;
        rmw = cfg_ecc_en && w && !(&be);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = be;
        #2;
        chk(req_ready == 1'b1, "R1 ready in idle", req_ready, 1);
        if (!rmw) begin
            chk(cmd_valid && cmd_write == w && cmd_addr == a && !cmd_own,
                w ? "R3/R4 write passthrough" : "R2 read passthrough",
                {cmd_valid, cmd_write, cmd_own, cmd_addr}, {1'b1, w, 1'b0, a});
            if (w) begin
                chk(cmd_mask == be && cmd_wdata == d, (&be) ? "R3 full word" : "R4 ecc off mask",
                    {cmd_mask, cmd_wdata}, {be, d});
            end
            tick();
            req_valid = 1'b0;
        end else begin
            chk(cmd_valid == 1'b0, "R5 no cmd at accept", cmd_valid, 0);
            tick();
            req_valid = 1'b0;
            #2;
            chk(cmd_valid && !cmd_write && cmd_own && cmd_addr == a, "R5 read of pair",
                {cmd_valid, cmd_write, cmd_own, cmd_addr}, {1'b1, 1'b0, 1'b1, a});
            chk(req_ready == 1'b0, "R7 busy", req_ready, 0);
            tick();
            for (int k = 0; k < wait_cyc; k++) begin
                rd_valid = 1'b1; rd_own = 1'b0; rd_sbe = 1'b0; rd_data = ~rdat;
                #2;
                chk(cmd_valid == 1'b0 && req_ready == 1'b0, "R5 wait for own data",
                    {cmd_valid, req_ready}, 0);
                tick();
            end
            rd_valid = 1'b1; rd_own = 1'b1; rd_data = rdat; rd_dbe = dbe; rd_sbe = 1'b0;
            #2;
            chk(cmd_valid == 1'b0, "R5 no write before data", cmd_valid, 0);
            tick();
            rd_valid = 1'b0; rd_own = 1'b0; rd_dbe = 1'b0;
            #2;
            if (dbe) begin
                chk(cmd_valid == 1'b0 && req_ready == 1'b1, "R10 abandoned",
                    {cmd_valid, req_ready}, {1'b0, 1'b1});
            end else begin
                chk(cmd_valid && cmd_write && cmd_own && cmd_addr == a && (&cmd_mask),
                    "R6 pair write", {cmd_valid, cmd_write, cmd_own, cmd_addr}, {1'b1, 1'b1, 1'b1, a});
                chk(cmd_wdata == merge_ref(rdat, d, be), "R6 merged data",
                    cmd_wdata, merge_ref(rdat, d, be));
                tick();
            end
        end
    endtask

    initial begin
        logic [NB-1:0] be;
        logic [DW-1:0] sd;
        sd = $urandom(32'd4242);
        repeat (3) tick();
        rst_n = 1'b1;
        #2;
        chk(cmd_valid == 1'b0 && req_ready == 1'b1, "R1 reset state", {cmd_valid, req_ready}, 2'b01);
        cmd_ready = 1'b0;
        #1;
        chk(req_ready == 1'b0, "R1 ready follows cmd_ready", req_ready, 0);
        cmd_ready = 1'b1;
        tick();

        // directed corners
        do_req(1'b1, 16'h0010, 32'hAABBCCDD, 4'b1111, 32'h0, 0, 1'b0);
        do_req(1'b1, 16'h0011, 32'h11223344, 4'b0000, 32'h55667788, 1, 1'b0);
        do_req(1'b1, 16'h0012, 32'h11223344, 4'b0101, 32'h55667788, 0, 1'b0);
        do_req(1'b0, 16'h0013, 32'h0, 4'b0000, 32'h0, 0, 1'b0);
        cfg_ecc_en = 1'b0;
        do_req(1'b1, 16'h0014, 32'hDEADBEEF, 4'b0010, 32'h0, 0, 1'b0);
        cfg_ecc_en = 1'b1;
        // R10: uncorrectable own read
        do_req(1'b1, 16'h0015, 32'hCAFEF00D, 4'b1000, 32'h12345678, 2, 1'b1);

        // random mix
        for (int n = 0; n < 300; n++) begin
            cfg_ecc_en = ($urandom % 4) != 0;
            be = NB'($urandom);
            do_req(($urandom % 3) != 0, AW'($urandom), $urandom, be, $urandom, $urandom % 4, 1'b0);
        end
        cfg_ecc_en = 1'b1;

        // R9: write-back disabled
        cfg_scrub_en = 1'b0;
        rd_valid = 1'b1; rd_own = 1'b0; rd_sbe = 1'b1; rd_addr = 16'h0AA0;
        tick();
        rd_valid = 1'b0; rd_sbe = 1'b0;
        expect_idle_cmd("R9 no scrub when disabled");
        chk(req_ready == 1'b1, "R9 still ready", req_ready, 1);
        tick();
        expect_idle_cmd("R9 no scrub later");
        cfg_scrub_en = 1'b1;

        // R8 + R11: scrub with a waiting request
        rd_valid = 1'b1; rd_own = 1'b0; rd_sbe = 1'b1; rd_addr = 16'h0BB0;
        tick();
        rd_valid = 1'b0; rd_sbe = 1'b0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0CC0;
        #2;
        chk(req_ready == 1'b0 && cmd_valid == 1'b0, "R11 request held", {req_ready, cmd_valid}, 0);
        tick();
        #2;
        chk(cmd_valid && !cmd_write && cmd_own && cmd_addr == 16'h0BB0, "R8 scrub read",
            {cmd_valid, cmd_write, cmd_own, cmd_addr}, {3'b101, 16'h0BB0});
        // R12: back-pressure on own read
        cmd_ready = 1'b0;
        tick();
        #2;
        chk(cmd_valid && cmd_own && !cmd_write && cmd_addr == 16'h0BB0, "R12 held read",
            {cmd_valid, cmd_own, cmd_addr}, {2'b11, 16'h0BB0});
        cmd_ready = 1'b1;
        tick();
        rd_valid = 1'b1; rd_own = 1'b1; rd_data = 32'h0F1E2D3C;
        tick();
        rd_valid = 1'b0; rd_own = 1'b0;
        #2;
        chk(cmd_valid && cmd_write && cmd_own && cmd_wdata == 32'h0F1E2D3C && cmd_addr == 16'h0BB0,
            "R8 scrub write", {cmd_valid, cmd_write, cmd_wdata}, {2'b11, 32'h0F1E2D3C});
        cmd_ready = 1'b0;
        tick();
        #2;
        chk(cmd_valid && cmd_write && cmd_wdata == 32'h0F1E2D3C, "R12 held write",
            {cmd_valid, cmd_write, cmd_wdata}, {2'b11, 32'h0F1E2D3C});
        chk(req_ready == 1'b0, "R7 busy during write", req_ready, 0);
        cmd_ready = 1'b1;
        tick();
        #2;
        chk(req_ready && cmd_valid && !cmd_own && cmd_addr == 16'h0CC0, "R11 request after scrub",
            {req_ready, cmd_valid, cmd_own, cmd_addr}, {3'b110, 16'h0CC0});
        tick();
        req_valid = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule